// File: doc/BRIEF.md
# Multiplexed Eight-Digit Display and Four-by-Six Keypad Scanner

This block refreshes an eight-digit, eight-segment multiplexed LED display and reads a four-row by six-column switch matrix through the same digit drive lines. Time is cut into slots of `CLK_HZ / SLOT_HZ` system clocks (1 ms with the default 1 kHz slot rate). Each slot serves one digit. The segment byte for that digit is latched from an eight-entry digit buffer, and then a one-cycle shift pulse moves a single enable bit one place along a digit shift register. A fresh enable bit enters the register once every eight slots. No binary digit number is decoded onto the digit lines. The extra indicator LEDs are wired as further segments, so they come out of the same eight segment lines.

The host fills the digit buffer through a simple write port (address, data, enable). A write reaches the display only when that digit's next slot starts. Digit lines 0 to 3 also drive the keypad rows. The six column inputs are sampled on the last cycle of each row slot. The frame's reading is the lowest key code seen across the four rows. A key code is reported once it has been read in three consecutive frames.

Each slot is run by a four-state machine:
- LOAD: latch the segment byte; segments dark.
- STROBE: shift pulse high; segments dark.
- SHOW: segments lit.
- SAMPLE: segments lit; columns sampled.

The transitions are LOAD→STROBE (always), STROBE→SHOW (always), SHOW→SAMPLE (when the slot timer reaches its second-to-last count), and SAMPLE→LOAD (always, which also advances the slot index). `SLOT_CYCLES` must be at least 4.

Top module: `dkscan_top`

## Requirements
- R1: A slot lasts exactly CLK_HZ/SLOT_HZ clocks. The selected digit line stays high from the third cycle of its slot through the second cycle of the following slot.
- R2: At most one of `dig_out` is high at any time. The high line moves 0,1,…,7 and then back to 0, one step per slot, and bit i of `dig_out` is digit i.
- R3: `dig_shift` is high for exactly one clock per slot, in the slot's second cycle. `dig_out` changes only in the cycle after that pulse.
- R4: `seg_out` is all zero in the first two cycles of every slot, while the byte is latched and while the shift pulse is high.
- R5: In cycles 3 to SLOT_CYCLES of a slot, `seg_out` equals the buffer entry of that slot's digit, as it stood just before the slot's first clock edge. `seg_out` is steady for that whole span.
- R6: A buffer write changes nothing in the current slot. A write that lands on the same clock edge that latches its own digit appears only on that digit's next pass.
- R7: After reset, `dig_out`, `seg_out`, `dig_shift` and `key_valid` are zero. All buffer entries read as zero, so the first pass lights nothing.
- R8: Digit lines 0–3 act as keypad rows 0–3. `col_in` bit c (high = closed) is sampled on the last cycle of each row's slot.
- R9: A frame's reading is taken as stable after three consecutive frames with the same reading. `key_valid` then pulses for one clock, in the first cycle of the slot that follows row 3's slot in the third frame.
- R10: `key_code` = row×6 + column, 5 bits. When several keys are closed, the lowest row wins, and within a row the lowest column wins.
- R11: A held key reports only once. A frame with no key closed re-arms the report. A change to a different reading restarts the three-frame count without needing a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Digit buffer write strobe |
| wr_addr | input | 3 | Digit buffer entry to write |
| wr_data | input | 8 | Segment byte (bit per segment or indicator) |
| col_in | input | 6 | Keypad column returns, high when closed |
| seg_out | output | 8 | Segment drive, high = lit |
| dig_out | output | 8 | One-hot digit drive; bits 0–3 are keypad rows |
| dig_shift | output | 1 | One-clock digit shift pulse |
| key_code | output | 5 | Code of the last reported key |
| key_valid | output | 1 | One-clock pulse when a key is reported |

## Verification
A host write and the slot's segment latch can fall on the same clock edge, and the outcome must be the old byte for this pass and the new byte for the next. The bench provokes this by driving a write to a digit in the very cycle that opens that digit's slot, both in a directed case and through random writes placed at phase 0. A bench shadow of the buffer is snapshotted before that write and checks the shown byte. Key reports come from frames in which two keys in the same or in different rows are closed together. The reported code and the cycle of `key_valid` are compared with a frame-level model of the three-frame rule.

// File: rtl/dkscan_pkg.sv
package dkscan_pkg;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_STROBE = 2'd1,
        ST_SHOW   = 2'd2,
        ST_SAMPLE = 2'd3
    } slot_state_e;

endpackage

// File: rtl/dkscan_slot_timer.sv
module dkscan_slot_timer #(
    parameter  int SLOT_CYCLES = 1000,
    localparam int CW          = $clog2(SLOT_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    output logic show_last
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(SLOT_CYCLES - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // last count that belongs to the lit span before the sample cycle
    assign show_last = (cnt_q == CW'(SLOT_CYCLES - 2));

endmodule

// File: rtl/dkscan_digit_shifter.sv
module dkscan_digit_shifter #(
    parameter int NUM_DIGITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic                  inject,
    output logic [NUM_DIGITS-1:0] en_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (step) begin
            en_q <= {en_q[NUM_DIGITS-2:0], inject};
        end
    end

endmodule

// File: rtl/dkscan_key_scanner.sv
module dkscan_key_scanner #(
    parameter  int NUM_ROWS   = 4,
    parameter  int NUM_COLS   = 6,
    parameter  int DEB_FRAMES = 3,
    parameter  int ROW_W      = 3,
    localparam int CODE_W     = $clog2(NUM_ROWS * NUM_COLS),
    localparam int COL_W      = $clog2(NUM_COLS),
    localparam int DW         = $clog2(DEB_FRAMES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_en,
    input  logic                frame_end,
    input  logic [ROW_W-1:0]    row_idx,
    input  logic [NUM_COLS-1:0] cols,
    output logic [CODE_W-1:0]   key_code,
    output logic                key_valid
);

    logic              cur_hit;
    logic [COL_W-1:0]  cur_col;
    logic [CODE_W-1:0] cur_code;
    logic              rd_hit;
    logic [CODE_W-1:0] rd_code;
    logic              acc_hit_q;
    logic [CODE_W-1:0] acc_code_q;
    logic [CODE_W-1:0] last_q;
    logic [DW-1:0]     cnt_q;
    logic              rep_q;
    logic              same;
    logic [DW-1:0]     run_n;
    logic              fire;
    logic [CODE_W-1:0] key_code_q;
    logic              key_valid_q;

    // lowest closed column wins: scan from the top so the last hit is lowest
    always_comb begin
        cur_hit = 1'b0;
        cur_col = '0;
        for (int c = NUM_COLS - 1; c >= 0; c--) begin
            if (cols[c]) begin
                cur_hit = 1'b1;
                cur_col = COL_W'(c);
            end
        end
    end

    assign cur_code = CODE_W'(row_idx) * CODE_W'(NUM_COLS) + CODE_W'(cur_col);

    // earlier rows in the frame take priority over the current one
    assign rd_hit  = acc_hit_q | cur_hit;
    assign rd_code = acc_hit_q ? acc_code_q : cur_code;

    assign same = rd_hit && (cnt_q != '0) && (rd_code == last_q);

    always_comb begin
        if (!rd_hit) begin
            run_n = '0;
        end else if (!same) begin
            run_n = DW'(1);
        end else if (cnt_q == DW'(DEB_FRAMES)) begin
            run_n = cnt_q;
        end else begin
            run_n = cnt_q + DW'(1);
        end
    end

    assign fire = rd_hit && (run_n == DW'(DEB_FRAMES)) && !(same && rep_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_hit_q   <= 1'b0;
            acc_code_q  <= '0;
            last_q      <= '0;
            cnt_q       <= '0;
            rep_q       <= 1'b0;
            key_code_q  <= '0;
            key_valid_q <= 1'b0;
        end else begin
            key_valid_q <= 1'b0;
            if (sample_en) begin
                if (frame_end) begin
                    acc_hit_q   <= 1'b0;
                    cnt_q       <= run_n;
                    rep_q       <= rd_hit && (fire || (same && rep_q));
                    key_valid_q <= fire;
                    if (rd_hit) begin
                        last_q <= rd_code;
                    end
                    if (fire) begin
                        key_code_q <= rd_code;
                    end
                end else begin
                    acc_hit_q  <= rd_hit;
                    acc_code_q <= rd_code;
                end
            end
        end
    end

    assign key_code  = key_code_q;
    assign key_valid = key_valid_q;

endmodule

// File: rtl/dkscan_top.sv
module dkscan_top
    import dkscan_pkg::*;
#(
    parameter  int CLK_HZ     = 1_000_000,
    parameter  int SLOT_HZ    = 1000,
    parameter  int NUM_DIGITS = 8,
    parameter  int SEG_W      = 8,
    parameter  int NUM_ROWS   = 4,
    parameter  int NUM_COLS   = 6,
    parameter  int DEB_FRAMES = 3,
    localparam int DIG_W      = $clog2(NUM_DIGITS),
    localparam int CODE_W     = $clog2(NUM_ROWS * NUM_COLS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [DIG_W-1:0]      wr_addr,
    input  logic [SEG_W-1:0]      wr_data,
    input  logic [NUM_COLS-1:0]   col_in,
    output logic [SEG_W-1:0]      seg_out,
    output logic [NUM_DIGITS-1:0] dig_out,
    output logic                  dig_shift,
    output logic [CODE_W-1:0]     key_code,
    output logic                  key_valid
);

    localparam int SLOT_CYCLES = CLK_HZ / SLOT_HZ;

    slot_state_e           state_q;
    slot_state_e           state_d;
    logic                  show_last;
    logic [SEG_W-1:0]      digit_buf_q [NUM_DIGITS];
    logic [SEG_W-1:0]      seg_hold_q;
    logic [DIG_W-1:0]      slot_idx_q;
    logic [NUM_DIGITS-1:0] dig_q;
    logic                  seg_gate;
    logic                  strobe;
    logic                  sample_now;
    logic                  inject;
    logic                  row_sample;
    logic                  last_row;

    dkscan_slot_timer #(
        .SLOT_CYCLES(SLOT_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .show_last(show_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:   state_d = ST_STROBE;
            ST_STROBE: state_d = ST_SHOW;
            ST_SHOW:   if (show_last) state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = ST_LOAD;
            default:   state_d = ST_LOAD;
        endcase
    end

    // per-state outputs
    always_comb begin
        seg_gate   = 1'b0;
        strobe     = 1'b0;
        sample_now = 1'b0;
        unique case (state_q)
            ST_LOAD:   ;
            ST_STROBE: strobe = 1'b1;
            ST_SHOW:   seg_gate = 1'b1;
            ST_SAMPLE: begin
                seg_gate   = 1'b1;
                sample_now = 1'b1;
            end
            default:   ;
        endcase
    end

    // host-written digit buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DIGITS; i++) begin
                digit_buf_q[i] <= '0;
            end
        end else if (wr_en && (int'(wr_addr) < NUM_DIGITS)) begin
            digit_buf_q[wr_addr] <= wr_data;
        end
    end

    // segment latch and slot index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_hold_q <= '0;
            slot_idx_q <= '0;
        end else begin
            if (state_q == ST_LOAD) begin
                seg_hold_q <= digit_buf_q[slot_idx_q];
            end
            if (sample_now) begin
                slot_idx_q <= (slot_idx_q == DIG_W'(NUM_DIGITS - 1)) ? '0
                                                                     : slot_idx_q + DIG_W'(1);
            end
        end
    end

    assign inject = (slot_idx_q == '0);

    dkscan_digit_shifter #(
        .NUM_DIGITS(NUM_DIGITS)
    ) u_shifter (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (strobe),
        .inject(inject),
        .en_q  (dig_q)
    );

    assign row_sample = sample_now && (int'(slot_idx_q) < NUM_ROWS);
    assign last_row   = (slot_idx_q == DIG_W'(NUM_ROWS - 1));

    dkscan_key_scanner #(
        .NUM_ROWS  (NUM_ROWS),
        .NUM_COLS  (NUM_COLS),
        .DEB_FRAMES(DEB_FRAMES),
        .ROW_W     (DIG_W)
    ) u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_en(row_sample),
        .frame_end(last_row),
        .row_idx  (slot_idx_q),
        .cols     (col_in),
        .key_code (key_code),
        .key_valid(key_valid)
    );

    assign seg_out   = (seg_gate && (|dig_q)) ? seg_hold_q : '0;
    assign dig_out   = dig_q;
    assign dig_shift = strobe;

endmodule

// File: rtl/dkscan_chk.sv
module dkscan_chk #(
    parameter int SEG_W      = 8,
    parameter int NUM_DIGITS = 8,
    parameter int CODE_W     = 5,
    parameter int NUM_KEYS   = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [SEG_W-1:0]      seg_out,
    input logic [NUM_DIGITS-1:0] dig_out,
    input logic                  dig_shift,
    input logic [CODE_W-1:0]     key_code,
    input logic                  key_valid
);

    p_one_digit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_out));

    p_pulse_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dig_shift |=> !dig_shift);

    p_digit_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dig_out) |-> $past(dig_shift));

    p_dark_on_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dig_shift |-> (seg_out == '0));

    p_dark_before_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dig_shift |-> ($past(seg_out) == '0));

    p_seg_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((seg_out != '0) && ($past(seg_out) != '0)) |-> $stable(seg_out));

    p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid);

    p_code_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> (int'(key_code) < NUM_KEYS));

endmodule

bind dkscan_top dkscan_chk #(
    .SEG_W     (SEG_W),
    .NUM_DIGITS(NUM_DIGITS),
    .CODE_W    (CODE_W),
    .NUM_KEYS  (NUM_ROWS * NUM_COLS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .seg_out  (seg_out),
    .dig_out  (dig_out),
    .dig_shift(dig_shift),
    .key_code (key_code),
    .key_valid(key_valid)
);

// File: tb/dkscan_top_tb.sv
module dkscan_top_tb;

    localparam int TCLK    = 10;
    localparam int CLK_HZ  = 16000;
    localparam int SLOT_HZ = 1000;
    localparam int N       = CLK_HZ / SLOT_HZ;
    localparam int NF      = 48;
    localparam int ND      = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [5:0] col_in;
    logic [7:0] seg_out;
    logic [7:0] dig_out;
    logic       dig_shift;
    logic [4:0] key_code;
    logic       key_valid;

    dkscan_top #(
        .CLK_HZ (CLK_HZ),
        .SLOT_HZ(SLOT_HZ)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .col_in   (col_in),
        .seg_out  (seg_out),
        .dig_out  (dig_out),
        .dig_shift(dig_shift),
        .key_code (key_code),
        .key_valid(key_valid)
    );

    always #(TCLK / 2) clk = ~clk;

    int ecnt = 0;
    always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

    // keypad matrix model: a closed key connects its row line to its column
    int ka = -1;
    int kb = -1;
    always_comb begin
        col_in = '0;
        if (ka >= 0 && dig_out[ka / 6]) col_in[ka % 6] = 1'b1;
        if (kb >= 0 && dig_out[kb / 6]) col_in[kb % 6] = 1'b1;
    end

    int ev_code [64];
    int ev_edge [64];
    int nev = 0;
    always @(negedge clk) begin
        if (rst_n && key_valid) begin
            if (nev < 64) begin
                ev_code[nev] = key_code;
                ev_edge[nev] = ecnt;
            end
            nev++;
        end
    end

    int xp_code [64];
    int xp_edge [64];
    int nxp = 0;
    int total = 0;
    int bad = 0;
    bit done = 0;
    int shadow [ND];
    int sched_a [NF];
    int sched_b [NF];
    int m_last = 0;
    int m_cnt = 0;
    bit m_rep = 0;

    task automatic chk_eq(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic goto(int e);
        while (ecnt < e) @(negedge clk);
    endtask

    task automatic write_digit(int a, int d);
        wr_en   = 1'b1;
        wr_addr = a[2:0];
        wr_data = d[7:0];
        shadow[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int frame_reading(int a, int b);
        if (a < 0) return b;
        if (b < 0) return a;
        return (a < b) ? a : b;
    endfunction

    task automatic run_slot(int j, int wp, int wa, int wd);
        int d;
        int exp;
        int prev;
        d    = j % ND;
        goto(j * N);
        exp  = shadow[d];
        prev = (j == 0) ? 0 : (1 << ((j - 1) % ND));
        chk_eq("R4 dark at latch", seg_out, 0);
        chk_eq("R2 previous digit held", dig_out, prev);
        chk_eq("R3 no pulse at latch", dig_shift, 0);
        if (wp == 0) write_digit(wa, wd);
        goto(j * N + 1);
        chk_eq("R3 pulse in second cycle", dig_shift, 1);
        chk_eq("R4 dark on pulse", seg_out, 0);
        chk_eq("R3 digit waits for pulse", dig_out, prev);
        goto(j * N + 2);
        chk_eq("R2 next digit", dig_out, 1 << d);
        chk_eq("R3 pulse one clock", dig_shift, 0);
        chk_eq("R5 shown byte", seg_out, exp);
        if (j == 0) chk_eq("R7 cleared buffer", seg_out, 0);
        if (wp >= 2) begin
            goto(j * N + wp);
            write_digit(wa, wd);
        end
        goto(j * N + N - 1);
        if (wp >= 0 && wa == d) chk_eq("R6 write deferred", seg_out, exp);
        else chk_eq("R1 lit for whole slot", seg_out, exp);
        chk_eq("R1 digit for whole slot", dig_out, 1 << d);
    endtask

    initial begin
        #(TCLK * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", ecnt, NF * 8 * N);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int f;
        void'($urandom(32'd1234));
        for (int i = 0; i < ND; i++) shadow[i] = 0;
        for (int i = 0; i < NF; i++) begin
            sched_a[i] = -1;
            sched_b[i] = -1;
        end
        // directed key frames
        for (int i = 2; i <= 6; i++) sched_a[i] = 7;          // R11 held, one report
        for (int i = 8; i <= 9; i++) sched_a[i] = 23;         // R9 two frames only
        for (int i = 11; i <= 13; i++) begin                  // R10 row priority
            sched_a[i] = 16;
            sched_b[i] = 11;
        end
        for (int i = 14; i <= 16; i++) begin                  // R10 column priority, R11 change
            sched_a[i] = 12;
            sched_b[i] = 15;
        end
        for (int i = 18; i <= 20; i++) sched_a[i] = 0;
        f = 22;
        while (f < NF - 2) begin
            int len;
            int c1;
            int c2;
            len = 1 + int'($urandom % 5);
            c1  = int'($urandom % 24);
            c2  = ($urandom % 3 == 0) ? int'($urandom % 24) : -1;
            for (int k = 0; k < len && f < NF - 2; k++) begin
                sched_a[f] = c1;
                sched_b[f] = c2;
                f++;
            end
            f += int'($urandom % 2);
        end

        repeat (3) @(negedge clk);
        chk_eq("R7 reset digits", dig_out, 0);
        chk_eq("R7 reset segments", seg_out, 0);
        chk_eq("R7 reset pulse", dig_shift, 0);
        chk_eq("R7 reset valid", key_valid, 0);
        rst_n = 1'b1;

        for (int fr = 0; fr < NF; fr++) begin
            int r;
            goto(fr * 8 * N);
            ka = sched_a[fr];
            kb = sched_b[fr];
            r  = frame_reading(ka, kb);
            if (r < 0) begin
                m_cnt = 0;
                m_rep = 0;
            end else if (m_cnt == 0 || r != m_last) begin
                m_last = r;
                m_cnt  = 1;
                m_rep  = 0;
            end else begin
                m_cnt++;
            end
            if (r >= 0 && m_cnt >= 3 && !m_rep) begin
                xp_code[nxp] = r;
                xp_edge[nxp] = (8 * fr + 4) * N;
                nxp++;
                m_rep = 1;
            end
            for (int s = 0; s < 8; s++) begin
                int j;
                int wp;
                int wa;
                int wd;
                j  = fr * 8 + s;
                wp = -1;
                wa = 0;
                wd = 0;
                if (j == 1) begin
                    wp = 5; wa = 1; wd = 8'hA5;                // R6 mid-slot own digit
                end else if (j == 29) begin
                    wp = 0; wa = 5; wd = 8'h3C;                // R6 same edge as latch
                end else if (j == 40) begin
                    wp = N - 3; wa = 1; wd = 8'h81;            // next digit, late write
                end else if ($urandom % 4 == 0) begin
                    wp = ($urandom % 2 == 0) ? 0 : 2 + int'($urandom % (N - 4));
                    wa = int'($urandom % 8);
                    wd = int'($urandom % 256);
                end
                run_slot(j, wp, wa, wd);
            end
        end

        chk_eq("R11 report count", nev, nxp);
        for (int i = 0; i < nxp && i < nev && i < 64; i++) begin
            chk_eq("R8/R10 reported code", ev_code[i], xp_code[i]);
            chk_eq("R9 report cycle", ev_edge[i], xp_edge[i]);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule